// File: doc/BRIEF.md
# Set-Associative Instruction Fetch Cache

This block sits between an instruction fetch port and a main-memory read port that returns one word at a time. Software controls it through a small control write port that carries two bits: an enable, and a choice between two victim policies. Each fetch also carries a cacheable flag. The tags are checked on every fetch while the cache is on. Only a cacheable fetch may be served from a line, or bring a line in.

On a cacheable miss, the block reads the whole aligned eight-word region that holds the requested word. It writes that region into one way of the indexed set and then returns the requested word. The way to replace is picked in one of two ways: the low bits of a free-running linear-feedback shift register, or a per-set rotating pointer. A one-cycle invalidate-all command drops every line at once.

Top module: `ifetch_cache`

## Requirements
- R1: After reset, no line is valid and the cache is off, so the first fetch is served by a single memory read. While reset is held, `fetch_done` and `mem_req` are low.
- R2: While the enable bit is 0, each fetch makes exactly one memory read at its word-aligned address and allocates nothing. Lines that were valid before the cache was turned off are still valid after it is turned back on.
- R3: While enabled, a cacheable fetch that hits returns the cached word with no memory read. `fetch_done` is high in the cycle after the request is accepted.
- R4: While enabled, a cacheable fetch that misses reads the eight words of its aligned line in ascending order, starting at word offset 0. It stores them in one way and then returns the requested word, which is the word at the fetch's own offset and not word 0.
- R5: A fetch with `fetch_cacheable` = 0 makes one memory read and never allocates a line, even while enabled. A line already present for that address stays intact.
- R6: The address fields are byte offset [1:0], word offset [4:2], set index [7:5] and tag [31:8]. Addresses that differ only in the tag compete for the four ways of one set.
- R7: With the policy bit at 0, the victim is the low two bits of an 8-bit LFSR.
  - The LFSR is seeded to 8'h01 by reset and steps every cycle.
  - At each step it shifts left, and bit 0 takes the XOR of bits 7, 5, 4 and 3 (x^8+x^6+x^5+x^4+1).
  - The value used is the one the LFSR holds in the cycle the fetch is accepted.
- R8: With the policy bit at 1, the victim is the set's 2-bit pointer. The pointer resets to 0 and advances by one, wrapping, after every fill into that set, whichever policy chose the victim of that fill.
- R9: A one-cycle `inv_all` pulse makes every line invalid when no fill is in progress. A pulse that arrives during a fill is ignored.
- R10: A fetch is presented with `fetch_valid` and held stable until `fetch_done`, which is a one-cycle pulse. The next fetch may be presented the cycle after. `fetch_done` never rises without a fetch outstanding.
- R11: `mem_req` and `mem_addr` stay stable until the cycle in which `mem_rvalid` is high. That cycle transfers one word.
- R12: A cycle with `cfg_we` high loads `cfg_enable` and `cfg_rr_mode`. The new values govern every fetch accepted after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_enable | input | 1 | Enable value loaded on `cfg_we` |
| cfg_rr_mode | input | 1 | Victim policy loaded on `cfg_we` (0 LFSR, 1 rotating pointer) |
| inv_all | input | 1 | One-cycle invalidate-all command |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_cacheable | input | 1 | Per-fetch cacheable flag |
| fetch_done | output | 1 | One-cycle pulse: `fetch_data` holds the instruction |
| fetch_data | output | 32 | Returned instruction word |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rvalid | input | 1 | Memory read data valid; completes the request |
| mem_rdata | input | 32 | Memory read data |

## Verification
The assertions rely on three things from the environment:
- The requester holds `fetch_valid`, `fetch_addr` and `fetch_cacheable` steady from presentation until `fetch_done`.
- Memory raises `mem_rvalid` only while `mem_req` is high.
- Control writes and `inv_all` are issued either between fetches or, for `inv_all`, during a fill.

The bench keeps to these rules:
- Every fetch is driven from one task that waits for the done pulse and one idle cycle before it returns.
- The modelled memory answers only an asserted request, after a programmable latency.
- The invalidate issued during a fill is timed a few cycles into a fill that is known to last at least sixteen cycles.

// File: rtl/ifc_pkg.sv
// Package ifc_pkg
// Shared definitions for the instruction fetch cache: the controller state
// encoding and the fixed parameters of the victim-selection LFSR.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ifc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_SINGLE = 2'd2,
        ST_RESP   = 2'd3
    } ifc_state_e;

    localparam int          LFSR_W    = 8;
    localparam logic [7:0]  LFSR_SEED = 8'h01;

endpackage

// File: rtl/ifc_victim_lfsr.sv
// Module ifc_victim_lfsr
// Free-running 8-bit Fibonacci LFSR (x^8+x^6+x^5+x^4+1) that supplies a
// pseudo-random way number from its low bits.
// Assumes: PICK_W <= 8; the seed is nonzero so the register never locks up.
module ifc_victim_lfsr #(
    parameter int PICK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PICK_W-1:0] pick
);
    import ifc_pkg::*;

    logic [LFSR_W-1:0] sr_q;
    logic              feedback;

    // Purpose: feedback tap XOR for the chosen polynomial.
    assign feedback = sr_q[7] ^ sr_q[5] ^ sr_q[4] ^ sr_q[3];

    // Purpose: seed on reset, shift every cycle afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= LFSR_SEED;
        end else begin
            sr_q <= {sr_q[LFSR_W-2:0], feedback};
        end
    end

    assign pick = sr_q[PICK_W-1:0];

    // R7: a nonzero seed with this feedback never reaches the all-zero state.
    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);

endmodule

// File: rtl/ifc_tag_store.sv
// Module ifc_tag_store
// Valid bits, tags and per-set rotating victim pointers. Does a parallel tag
// compare for one lookup set and updates on clear, commit and invalidate-all.
// Assumes: clr_en and put_en never target the same way in one cycle; the
// caller gates inv_all so it never coincides with put_en.
module ifc_tag_store #(
    parameter  int SETS  = 8,
    parameter  int WAYS  = 4,
    parameter  int TAG_W = 24,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] rr_way,
    input  logic             inv_all,
    input  logic             clr_en,
    input  logic [SET_W-1:0] clr_set,
    input  logic [WAY_W-1:0] clr_way,
    input  logic             put_en,
    input  logic [SET_W-1:0] put_set,
    input  logic [WAY_W-1:0] put_way,
    input  logic [TAG_W-1:0] put_tag
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAY_W-1:0] rr_q  [SETS];
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] rr_nxt;
    logic             any_valid;

    // Purpose: one comparator per way on the lookup set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    assign hit = |hit_vec;

    // Purpose: encode the matching way number.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Purpose: summary of all valid bits, used only by the checks below.
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld_q[s]);
    end

    // Purpose: valid bits: cleared by reset/invalidate, dropped at fill start, set at commit.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else begin
            if (clr_en) vld_q[clr_set][clr_way] <= 1'b0;
            if (put_en) vld_q[put_set][put_way] <= 1'b1;
        end
    end

    // Purpose: tag written when a line fill commits.
    always_ff @(posedge clk) begin
        if (put_en) tag_q[put_set][put_way] <= put_tag;
    end

    assign rr_nxt = rr_q[put_set] + 1'b1;
    assign rr_way = rr_q[lk_set];

    // Purpose: rotating pointer per set, advanced on every commit into that set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (put_en) begin
            rr_q[put_set] <= rr_nxt;
        end
    end

    // R1: the cycle after reset, no line is valid.
    a_r1_reset_empty: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> !any_valid);
    // R9: an accepted invalidate leaves no valid line.
    a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !any_valid);
    // R6: one address never matches two ways.
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R8: the pointer of the filled set steps by one.
    a_r8_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
        put_en |=> rr_q[$past(put_set)] == $past(rr_nxt));

endmodule

// File: rtl/ifc_line_store.sv
// Module ifc_line_store
// Instruction word storage addressed by {set, way, word}: one write port for
// the fill sequencer and one combinational read port for hits.
// Assumes: SETS, WAYS and WORDS are powers of two.
module ifc_line_store #(
    parameter  int SETS   = 8,
    parameter  int WAYS   = 4,
    parameter  int WORDS  = 8,
    parameter  int DATA_W = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = SET_W + WAY_W + OFF_W,
    localparam int DEPTH  = SETS * WAYS * WORDS
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    assign wr_idx  = {wr_set, wr_way, wr_word};
    assign rd_idx  = {rd_set, rd_way, rd_word};
    assign rd_data = mem_q[rd_idx];

    // Purpose: store one fill word per memory beat.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

endmodule

// File: rtl/ifetch_cache.sv
// Module ifetch_cache
// Read-only instruction cache: control register, lookup, miss/uncached
// sequencing, and the choice between LFSR and rotating-pointer victims.
// Assumes: the fetch request is held until fetch_done; memory raises
// mem_rvalid only while mem_req is high.
module ifetch_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 8,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_enable,
    input  logic              cfg_rr_mode,
    input  logic              inv_all,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_cacheable,
    output logic              fetch_done,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    import ifc_pkg::*;

    localparam int WAY_W   = $clog2(WAYS);
    localparam int SET_W   = $clog2(SETS);
    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int BYTE_W  = $clog2(DATA_W / 8);
    localparam int SET_LSB = BYTE_W + OFF_W;
    localparam int TAG_LSB = SET_LSB + SET_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;
    localparam logic [OFF_W-1:0]  LAST_WORD = OFF_W'(LINE_WORDS - 1);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'((DATA_W / 8) - 1);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 8);

    ifc_state_e        state_q;
    logic              en_q;
    logic              rr_mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [OFF_W-1:0]  cnt_q;
    logic [WAY_W-1:0]  victim_q;
    logic [DATA_W-1:0] data_q;

    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic [OFF_W-1:0]  lk_word;
    logic [SET_W-1:0]  fl_set;
    logic [TAG_W-1:0]  fl_tag;
    logic [OFF_W-1:0]  fl_word;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  rr_way;
    logic [WAY_W-1:0]  rnd_way;
    logic [WAY_W-1:0]  victim_d;
    logic [DATA_W-1:0] line_rd;
    logic              accept;
    logic              take_hit;
    logic              start_fill;
    logic              beat;
    logic              commit;
    logic              inv_ok;

    // Purpose: split the live fetch address and the held fill address into fields.
    assign lk_set  = fetch_addr[TAG_LSB-1:SET_LSB];
    assign lk_tag  = fetch_addr[ADDR_W-1:TAG_LSB];
    assign lk_word = fetch_addr[SET_LSB-1:BYTE_W];
    assign fl_set  = addr_q[TAG_LSB-1:SET_LSB];
    assign fl_tag  = addr_q[ADDR_W-1:TAG_LSB];
    assign fl_word = addr_q[SET_LSB-1:BYTE_W];

    // Purpose: decode what an accepted fetch will do.
    assign accept     = (state_q == ST_IDLE) && fetch_valid;
    assign take_hit   = accept && en_q && fetch_cacheable && hit;
    assign start_fill = accept && en_q && fetch_cacheable && !hit;
    assign victim_d   = rr_mode_q ? rr_way : rnd_way;
    assign beat       = mem_req && mem_rvalid;
    assign commit     = (state_q == ST_FILL) && mem_rvalid && (cnt_q == LAST_WORD);
    assign inv_ok     = inv_all && (state_q != ST_FILL);

    ifc_victim_lfsr #(.PICK_W(WAY_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .pick  (rnd_way)
    );

    ifc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_set  (lk_set),
        .lk_tag  (lk_tag),
        .hit     (hit),
        .hit_way (hit_way),
        .rr_way  (rr_way),
        .inv_all (inv_ok),
        .clr_en  (start_fill),
        .clr_set (lk_set),
        .clr_way (victim_d),
        .put_en  (commit),
        .put_set (fl_set),
        .put_way (victim_q),
        .put_tag (fl_tag)
    );

    ifc_line_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_lines (
        .clk     (clk),
        .wr_en   ((state_q == ST_FILL) && mem_rvalid),
        .wr_set  (fl_set),
        .wr_way  (victim_q),
        .wr_word (cnt_q),
        .wr_data (mem_rdata),
        .rd_set  (lk_set),
        .rd_way  (hit_way),
        .rd_word (lk_word),
        .rd_data (line_rd)
    );

    // Purpose: control register loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            rr_mode_q <= 1'b0;
        end else if (cfg_we) begin
            en_q      <= cfg_enable;
            rr_mode_q <= cfg_rr_mode;
        end
    end

    // Purpose: fetch sequencer covering hit, line fill and uncached single read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            cnt_q    <= '0;
            victim_q <= '0;
            data_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (fetch_valid) begin
                        addr_q <= fetch_addr;
                        cnt_q  <= '0;
                        if (take_hit) begin
                            data_q  <= line_rd;
                            state_q <= ST_RESP;
                        end else if (start_fill) begin
                            victim_q <= victim_d;
                            state_q  <= ST_FILL;
                        end else begin
                            state_q <= ST_SINGLE;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_rvalid) begin
                        if (cnt_q == fl_word) data_q <= mem_rdata;
                        if (cnt_q == LAST_WORD) state_q <= ST_RESP;
                        else                    cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_SINGLE: begin
                    if (mem_rvalid) begin
                        data_q  <= mem_rdata;
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: memory port drive, with the line base plus a counter during a fill.
    assign mem_req    = (state_q == ST_FILL) || (state_q == ST_SINGLE);
    assign mem_addr   = (state_q == ST_FILL) ? {addr_q[ADDR_W-1:SET_LSB], cnt_q, {BYTE_W{1'b0}}}
                                             : (addr_q & WORD_MASK);
    assign fetch_done = (state_q == ST_RESP);
    assign fetch_data = data_q;

    // R11: a pending memory request holds its address.
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    // R4: fill beats walk upwards one word at a time.
    a_r4_fill_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && (state_q == ST_FILL) && (cnt_q != LAST_WORD)) |=> (mem_addr == $past(mem_addr) + WORD_STEP));
    // R4: a fill begins at the first word of the line.
    a_r4_fill_base: assert property (@(posedge clk) disable iff (!rst_n)
        start_fill |=> (mem_addr[SET_LSB-1:0] == '0));
    // R3: a hit answers in the next cycle.
    a_r3_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
        take_hit |=> fetch_done);
    // R10: the done indication lasts a single cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> !fetch_done);
    // R2: a fetch accepted while disabled goes to a single memory read.
    a_r2_off_single: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !en_q) |=> (state_q == ST_SINGLE));

endmodule

// File: tb/ifetch_cache_tb.sv
module ifetch_cache_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_enable, cfg_rr_mode, inv_all;
    logic        fetch_valid, fetch_cacheable;
    logic [31:0] fetch_addr;
    logic        fetch_done;
    logic [31:0] fetch_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifetch_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
        .cfg_rr_mode(cfg_rr_mode), .inv_all(inv_all), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_cacheable(fetch_cacheable),
        .fetch_done(fetch_done), .fetch_data(fetch_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Reference model state
    int unsigned tag_m [8][4];
    bit          val_m [8][4];
    int          rr_m  [8];
    bit          en_m, rrsel_m;
    logic [7:0]  lfsr_m;
    logic [31:0] memq [$];
    int          n_vec = 0, n_bad = 0;
    int          mem_lat = 2, mwait = 0;
    bit          pend = 0, busy = 0, ended = 0;
    logic [31:0] pend_addr;

    function automatic logic [31:0] mdat(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h3C96_A55A;
    endfunction

    function automatic logic [31:0] mk(input int t, input int s, input int o);
        return (32'(t) << 8) | (32'(s) << 5) | (32'(o) << 2);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // LFSR reference (R7): seeded by reset, shifted left each cycle, bit0 = b7^b5^b4^b3
    always @(posedge clk) begin
        if (!rst_n) lfsr_m = 8'h01;
        else        lfsr_m = {lfsr_m[6:0], lfsr_m[7] ^ lfsr_m[5] ^ lfsr_m[4] ^ lfsr_m[3]};
    end

    // Memory model with programmable latency; checks request hold (R11)
    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mem_rvalid = 1'b0; mwait = 0; pend = 0;
        end else if (mem_rvalid) begin
            mem_rvalid = 1'b0; mwait = 0; pend = 0;
        end else begin
            if (pend) chk(mem_addr == pend_addr, "R11", "mem_addr held", mem_addr, pend_addr);
            else begin pend = 1; pend_addr = mem_addr; end
            if (mwait >= mem_lat - 1) begin
                mem_rvalid = 1'b1; mem_rdata = mdat(mem_addr);
                memq.push_back(mem_addr); mwait = 0;
            end else mwait++;
        end
    end

    // Per-cycle check: no completion without an outstanding fetch (R10)
    always @(negedge clk) begin
        if (rst_n && !busy) chk(!fetch_done, "R10", "spurious fetch_done", 32'(fetch_done), 32'd0);
    end

    task automatic cfg(input bit en, input bit rr);
        cfg_we = 1; cfg_enable = en; cfg_rr_mode = rr;
        @(negedge clk);
        cfg_we = 0;
        en_m = en; rrsel_m = rr;
    endtask

    task automatic fetch(input logic [31:0] a, input bit c);
        int s = int'(a[7:5]);
        int unsigned t = a[31:8];
        int w = -1;
        int kind, vic, cyc = 0;
        logic [31:0] got, exp_d, base;
        string rq;
        for (int k = 0; k < 4; k++) if (val_m[s][k] && tag_m[s][k] == t) w = k;
        kind  = (en_m && c && w >= 0) ? 0 : ((en_m && c) ? 2 : 1);
        vic   = rrsel_m ? rr_m[s] : int'(lfsr_m[1:0]);
        exp_d = mdat({a[31:2], 2'b00});
        base  = {a[31:5], 5'b0};
        memq.delete();
        busy = 1;
        fetch_valid = 1; fetch_addr = a; fetch_cacheable = c;
        do begin @(negedge clk); cyc++; end while (!fetch_done && cyc < 200);
        got = fetch_data;
        fetch_valid = 0;
        rq = (kind == 0) ? "R3" : ((kind == 2) ? "R4" : (en_m ? "R5" : "R2"));
        chk(cyc < 200, "R10", "fetch completes", 32'(cyc), 32'd200);
        chk(got == exp_d, rq, "fetch data", got, exp_d);
        if (kind == 0) begin
            chk(memq.size() == 0, "R3", "no memory read on hit", 32'(memq.size()), 32'd0);
            chk(cyc == 1, "R3", "hit latency", 32'(cyc), 32'd1);
        end else if (kind == 1) begin
            chk(memq.size() == 1, rq, "single read count", 32'(memq.size()), 32'd1);
            if (memq.size() >= 1) chk(memq[0] == {a[31:2], 2'b00}, rq, "single read addr", memq[0], {a[31:2], 2'b00});
        end else begin
            chk(memq.size() == 8, "R4", "fill beat count", 32'(memq.size()), 32'd8);
            for (int i = 0; i < 8 && i < memq.size(); i++)
                chk(memq[i] == base + 32'(4 * i), "R4", "fill order", memq[i], base + 32'(4 * i));
            tag_m[s][vic] = t; val_m[s][vic] = 1;
            rr_m[s] = (rr_m[s] + 1) % 4;   // R8: advances on every fill
        end
        @(negedge clk);
        busy = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_enable = 0; cfg_rr_mode = 0; inv_all = 0;
        fetch_valid = 0; fetch_addr = '0; fetch_cacheable = 0;
        en_m = 0; rrsel_m = 0;
        for (int s = 0; s < 8; s++) begin
            rr_m[s] = 0;
            for (int k = 0; k < 4; k++) begin val_m[s][k] = 0; tag_m[s][k] = 0; end
        end
        repeat (3) @(negedge clk);
        chk(!fetch_done, "R1", "fetch_done in reset", 32'(fetch_done), 32'd0);
        chk(!mem_req, "R1", "mem_req in reset", 32'(mem_req), 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R1: cacheable fetch after reset is a single read (cache off)
        fetch(32'h0000_0104, 1);
        // R12: turning the cache on with LFSR victims
        cfg(1, 0);
        fetch(32'h0000_0104, 1);
        fetch(32'h0000_011C, 1);
        fetch(32'h0000_0100, 1);
        // R5: uncached fetch of a present line leaves it intact
        fetch(32'h0000_0108, 0);
        fetch(32'h0000_0108, 1);
        // R5: uncached miss does not allocate
        fetch(32'h0000_2014, 0);
        fetch(32'h0000_2014, 1);

        // R6 and R8: six tags competing for set 3 with rotating victims
        mem_lat = 3;
        cfg(1, 1);
        for (int t = 1; t <= 6; t++) fetch(mk(t, 3, t % 8), 1);
        for (int t = 1; t <= 6; t++) fetch(mk(t, 3, (t + 3) % 8), 1);

        // R7: eight tags competing for set 5 with LFSR victims
        mem_lat = 1;
        cfg(1, 0);
        for (int t = 20; t < 28; t++) fetch(mk(t, 5, t % 8), 1);
        for (int r = 0; r < 2; r++)
            for (int t = 20; t < 28; t++) fetch(mk(t, 5, (t + r) % 8), 1);

        // R9: invalidate while idle drops every line
        inv_all = 1; @(negedge clk); inv_all = 0;
        for (int s = 0; s < 8; s++) for (int k = 0; k < 4; k++) val_m[s][k] = 0;
        fetch(32'h0000_0104, 1);

        // R9: invalidate during a fill is ignored
        mem_lat = 2;
        fork
            fetch(32'h0000_3028, 1);
            begin repeat (4) @(negedge clk); inv_all = 1; @(negedge clk); inv_all = 0; end
        join
        fetch(32'h0000_0104, 1);
        fetch(32'h0000_3020, 1);

        // R2: disabled fetches go to memory, lines survive re-enable (R12)
        cfg(0, 0);
        fetch(32'h0000_0104, 1);
        fetch(32'h0000_0110, 0);
        cfg(1, 0);
        fetch(32'h0000_0104, 1);
        fetch(32'h0000_4000, 1);
        fetch(32'h0000_401C, 1);

        finish_run();
    end
endmodule